// File: doc/BRIEF.md
# Windowed Watchdog Timer with Guarded Feed Sequence

The block is a watchdog for a synchronous register bus. A 24-bit down-counter, once started, decrements by one on each cycle in which the tick input is high. Software keeps it from expiring by writing a two-byte key sequence to a feed register. The sequence reloads the counter from a programmable reload value. The counter never wraps below zero, and reaching zero while it runs is a time-out.

A feed that arrives while the count is still above a programmable window value counts as a fault. So does a key sequence that is broken by another write or that ends in the wrong byte. A fault raises the same sticky time-out flag as an expiry. That flag either feeds an interrupt path or asks for a chip reset, depending on a select bit that can only ever be set. A warning flag rises when the count reaches a programmable warning value, and the warning interrupt is that flag gated by the enable bit. A write-once guard bit locks the reload value until the count is low enough.

Register reads are combinational from the address. Writes take effect at the clock edge in which `wrEn` is high. All state resets to zero.

Top module: `wwdt_top`

## Requirements
- R1: After reset every register reads 0, and `warnIrq` and `resetReq` are low.
- R2: Addresses are 0x00 control, 0x04 reload, 0x08 feed, 0x0C count, 0x14 warning, 0x18 window. Reload, window and count are 24 bits wide and the warning value is 10 bits wide. Bits above each width are dropped on a write and read as 0. The feed register and control bits 31:5 read 0. Control bit fields are 0 enable, 1 reset-select, 2 time-out flag, 3 warning flag, 4 guard.
- R3: Writing 0xAA and then 0x55 in the low byte of the feed register, as two consecutive writes, loads the count from the reload value. If enable is 1 at that point, the counter starts running. While running, each high `tickEn` cycle lowers the count by one. While stopped, ticks leave the count unchanged.
- R4: Enable can be written 0 or 1 while the counter is stopped. Once the counter runs, enable stays 1 until reset.
- R5: The reset-select bit, once written to 1, ignores later writes of 0.
- R6: While running with a count of 0, the time-out flag is forced to 1 and the count stays at 0. `resetReq` is high whenever both the time-out flag and reset-select are 1.
- R7: While running, the warning flag is set in the cycle after the count equals the warning value. Writing 1 to bit 3 clears it, unless the count still equals the warning value. `warnIrq` is the warning flag ANDed with enable.
- R8: The guard bit, once set, ignores writes of 0. While it is set, a reload write takes effect only if the count is below both the warning value and the window value. Otherwise the write is dropped and the time-out flag is set.
- R9: A completed key sequence while running with the count above the window value sets the time-out flag and leaves the count unchanged.
- R10: While armed by 0xAA, any next write other than 0x55 to the feed register disarms the sequence without reloading. If the counter runs, this also sets the time-out flag. While stopped, the abort has no other effect.
- R11: Writing 0 to control bit 2 clears the time-out flag and writing 1 has no effect. A fault condition in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Byte address of the register access |
| wrEn | input | 1 | Write strobe for one cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| tickEn | input | 1 | Count-down enable pulse |
| warnIrq | output | 1 | Warning interrupt |
| resetReq | output | 1 | Chip reset request |

## Verification
The hardest state to reach is a running counter whose time-out flag cannot be cleared, because it holds at zero, while the warning flag, set on the way down, still can be. The stimulus gets there in stages. It first starts the counter with a feed and passes through the early-feed, aborted-sequence and guarded-reload faults, clearing the flag after each one. It then sets reset-select and ticks the count through the warning value down to zero. At that point it writes a control word that asks to clear both flags, and checks that only the warning flag drops while `resetReq` stays high.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 24;
  localparam int unsigned WARN_W = 10;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] A_RELOAD = 5'h04;
  localparam logic [ADDR_W-1:0] A_FEED   = 5'h08;
  localparam logic [ADDR_W-1:0] A_COUNT  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_WARN   = 5'h14;
  localparam logic [ADDR_W-1:0] A_WIN    = 5'h18;

  localparam logic [7:0] KEY_ARM  = 8'hAA;
  localparam logic [7:0] KEY_FIRE = 8'h55;

  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobe_t;

  typedef struct packed {
    logic running;
    logic guard;
    logic warnFlag;
    logic toFlag;
    logic rstSel;
    logic enable;
  } wdtState_t;
endpackage

// File: rtl/wwdt_count.sv
module wwdt_count
  import wwdt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  cntStrobe_t   strobe,
  input  logic [W-1:0] reloadVal,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (strobe.load) cnt <= reloadVal;
    else if (strobe.dec)  cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/wwdt_ctrl.sv
module wwdt_ctrl
  import wwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickEn,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rdData,
  output cntStrobe_t        strobe,
  output logic [CNT_W-1:0]  reloadVal,
  output wdtState_t         st,
  output logic              warnIrq,
  output logic              resetReq
);
  localparam int unsigned PAD_W = CNT_W - WARN_W;

  logic [WARN_W-1:0] warnVal;
  logic [CNT_W-1:0]  winVal, warnWide;
  logic armed;
  logic wrCtrl, wrReload, wrFeed, wrWarn, wrWin;
  logic feedArm, feedFire, feedAbort, earlyFeed, goodFeed;
  logic guardOk, guardBlock, faultEvt, toEvt, warnEvt;

  assign warnWide = {{PAD_W{1'b0}}, warnVal};
  assign wrCtrl   = wrEn && (addr == A_CTRL);
  assign wrReload = wrEn && (addr == A_RELOAD);
  assign wrFeed   = wrEn && (addr == A_FEED);
  assign wrWarn   = wrEn && (addr == A_WARN);
  assign wrWin    = wrEn && (addr == A_WIN);

  assign feedArm    = wrFeed && !armed && (wrData[7:0] == KEY_ARM);
  assign feedFire   = wrFeed && armed && (wrData[7:0] == KEY_FIRE);
  assign feedAbort  = wrEn && armed && !feedFire;
  assign earlyFeed  = feedFire && st.running && (cnt > winVal);
  assign goodFeed   = feedFire && !earlyFeed;
  assign guardOk    = (cnt < warnWide) && (cnt < winVal);
  assign guardBlock = wrReload && st.guard && !guardOk;
  assign toEvt      = st.running && (cnt == '0);
  assign warnEvt    = st.running && (cnt == warnWide);
  assign faultEvt   = toEvt || guardBlock || (st.running && (feedAbort || earlyFeed));

  assign strobe.load = goodFeed;
  assign strobe.dec  = st.running && tickEn && (cnt != '0) && !goodFeed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= '0;
      armed     <= 1'b0;
      reloadVal <= '0;
      warnVal   <= '0;
      winVal    <= '0;
    end else begin
      if (wrEn) armed <= feedArm;
      if (wrReload && !guardBlock) reloadVal <= wrData[CNT_W-1:0];
      if (wrWarn) warnVal <= wrData[WARN_W-1:0];
      if (wrWin)  winVal  <= wrData[CNT_W-1:0];
      if (goodFeed && st.enable) st.running <= 1'b1;
      if (wrCtrl) begin
        st.enable <= wrData[0] || st.running;
        st.rstSel <= st.rstSel || wrData[1];
        st.guard  <= st.guard || wrData[4];
      end
      if (faultEvt)                  st.toFlag <= 1'b1;
      else if (wrCtrl && !wrData[2]) st.toFlag <= 1'b0;
      if (warnEvt)                   st.warnFlag <= 1'b1;
      else if (wrCtrl && wrData[3])  st.warnFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      A_CTRL:   rdData[4:0] = {st.guard, st.warnFlag, st.toFlag, st.rstSel, st.enable};
      A_RELOAD: rdData[CNT_W-1:0]  = reloadVal;
      A_COUNT:  rdData[CNT_W-1:0]  = cnt;
      A_WARN:   rdData[WARN_W-1:0] = warnVal;
      A_WIN:    rdData[CNT_W-1:0]  = winVal;
      default:  rdData = '0;
    endcase
  end

  assign warnIrq  = st.warnFlag && st.enable;
  assign resetReq = st.toFlag && st.rstSel;
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  addr,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        tickEn,
  output logic        warnIrq,
  output logic        resetReq
);
  cntStrobe_t       strobe;
  wdtState_t        st;
  logic [CNT_W-1:0] cnt, reloadVal;

  wwdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .tickEn(tickEn), .cnt(cnt), .rdData(rdData), .strobe(strobe),
    .reloadVal(reloadVal), .st(st), .warnIrq(warnIrq), .resetReq(resetReq)
  );

  wwdt_count #(.W(CNT_W)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal), .cnt(cnt)
  );
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk
  import wwdt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cnt,
  input cntStrobe_t       strobe,
  input wdtState_t        st
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |=> cnt == $past(cnt) - CNT_W'(1)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !strobe.load) |=> cnt == '0); // R6
  AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (st.running && cnt == '0) |=> st.toFlag); // R6
  AST_RUN_KEEPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    st.running |=> (st.running && st.enable)); // R4
  AST_RSTSEL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    st.rstSel |=> st.rstSel); // R5
  AST_GUARD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    st.guard |=> st.guard); // R8
endmodule

bind wwdt_top wwdt_chk u_chk (
  .clk(clk), .rstN(rstN), .cnt(cnt), .strobe(strobe), .st(st)
);

// File: tb/tb_wwdt_top.sv
`timescale 1ns/1ps
module tb_wwdt_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] addr = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic tickEn = 1'b0;
  logic warnIrq, resetReq;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wwdt_top dut (.clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .tickEn(tickEn), .warnIrq(warnIrq), .resetReq(resetReq));

  // {write, addr, data, requirement number}
  localparam int NV = 22;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 5'h00, 32'h0, 4'd1},           // R1 control
    {1'b0, 5'h0C, 32'h0, 4'd1},           // R1 count
    {1'b0, 5'h04, 32'h0, 4'd1},           // R1 reload
    {1'b1, 5'h04, 32'hFF123456, 4'd2},
    {1'b0, 5'h04, 32'h00123456, 4'd2},    // R2 24-bit reload
    {1'b1, 5'h14, 32'h0000FFFF, 4'd2},
    {1'b0, 5'h14, 32'h000003FF, 4'd2},    // R2 10-bit warning
    {1'b1, 5'h18, 32'hABCDEF01, 4'd2},
    {1'b0, 5'h18, 32'h00CDEF01, 4'd2},    // R2 24-bit window
    {1'b0, 5'h08, 32'h0, 4'd2},           // R2 feed reads 0
    {1'b1, 5'h08, 32'h000000AA, 4'd10},
    {1'b1, 5'h04, 32'h00000010, 4'd10},
    {1'b0, 5'h00, 32'h0, 4'd10},          // R10 stopped abort: no flag
    {1'b0, 5'h0C, 32'h0, 4'd10},          // R10 no reload
    {1'b1, 5'h08, 32'h000000AA, 4'd3},
    {1'b1, 5'h08, 32'h00000055, 4'd3},
    {1'b0, 5'h0C, 32'h00000010, 4'd3},    // R3 feed loads count
    {1'b1, 5'h00, 32'hFFFFFFE0, 4'd2},
    {1'b0, 5'h00, 32'h0, 4'd2},           // R2 control upper bits
    {1'b1, 5'h00, 32'h00000001, 4'd4},
    {1'b1, 5'h00, 32'h00000000, 4'd4},
    {1'b0, 5'h00, 32'h0, 4'd4}            // R4 enable clears when stopped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [4:0] a, input logic [31:0] exp);
    addr = a; #0.5;
    check(tag, rdData, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic feed();
    wr(5'h08, 32'hAA); wr(5'h08, 32'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 warnIrq", {31'b0, warnIrq}, 0);
    check("R1 resetReq", {31'b0, resetReq}, 0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) wr(VEC[i][40:36], VEC[i][35:4]);
      else rdCheck($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][40:36], VEC[i][35:4]);
    end
    ticks(2);
    rdCheck("R3 stopped ticks", 5'h0C, 32'h10);

    wr(5'h04, 20); wr(5'h14, 5); wr(5'h18, 10); wr(5'h00, 1);
    feed();
    rdCheck("R3 start count", 5'h0C, 20);
    feed();                                    // early: 20 > 10
    rdCheck("R9 early count kept", 5'h0C, 20);
    rdCheck("R9 early flag", 5'h00, 32'h5);
    wr(5'h00, 32'h5);
    rdCheck("R11 write 1 keeps flag", 5'h00, 32'h5);
    wr(5'h00, 32'h0);
    rdCheck("R4 R11 enable held, flag cleared", 5'h00, 32'h1);
    ticks(10);
    rdCheck("R3 ten ticks", 5'h0C, 10);
    feed();
    rdCheck("R3 feed at window", 5'h0C, 20);
    rdCheck("R3 no flag", 5'h00, 32'h1);
    wr(5'h08, 32'hAA); wr(5'h18, 10);
    rdCheck("R10 abort by other write", 5'h00, 32'h5);
    wr(5'h00, 1);
    wr(5'h08, 32'hAA); wr(5'h08, 32'h11);
    rdCheck("R10 bad second byte", 5'h00, 32'h5);
    rdCheck("R10 no reload", 5'h0C, 20);
    wr(5'h00, 1);
    ticks(15);
    rdCheck("R7 count at warn", 5'h0C, 5);
    rdCheck("R7 warn set", 5'h00, 32'h9);
    check("R7 warnIrq", {31'b0, warnIrq}, 1);
    wr(5'h00, 32'h9);
    rdCheck("R7 clear blocked at equal", 5'h00, 32'h9);
    ticks(1);
    wr(5'h00, 32'h9);
    rdCheck("R7 clear below", 5'h00, 32'h1);
    check("R7 warnIrq low", {31'b0, warnIrq}, 0);
    wr(5'h00, 32'h11);
    wr(5'h04, 30);
    rdCheck("R8 reload allowed when low", 5'h04, 30);
    wr(5'h00, 32'h1);
    rdCheck("R8 guard sticky", 5'h00, 32'h11);
    feed();
    wr(5'h04, 40);
    rdCheck("R8 reload locked", 5'h04, 30);
    rdCheck("R8 violation flag", 5'h00, 32'h15);
    wr(5'h00, 32'h11);
    wr(5'h00, 32'h13);
    wr(5'h00, 32'h11);
    rdCheck("R5 reset select sticky", 5'h00, 32'h13);
    check("R6 no request yet", {31'b0, resetReq}, 0);
    ticks(30);
    rdCheck("R6 count zero", 5'h0C, 0);
    rdCheck("R6 timeout flags", 5'h00, 32'h1F);
    check("R6 resetReq", {31'b0, resetReq}, 1);
    ticks(3);
    rdCheck("R6 no wrap", 5'h0C, 0);
    wr(5'h00, 32'h1B);
    rdCheck("R6 R7 only warn clears", 5'h00, 32'h17);
    check("R6 resetReq held", {31'b0, resetReq}, 1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule